// File: doc/BRIEF.md
# Asynchronous SRAM Write-Cycle Sequencer

This block is a clocked controller that turns one write request at a time into a correctly timed write cycle on the asynchronous pins of an external static RAM. It drives the address bus, an active-low chip enable, an active-low write enable, the data-bus value together with its output enable, and an active-low save strobe that is held high for as long as the block runs. A request carries an address, a data word and a shape select. The select chooses whether the write enable or the chip enable marks out the write pulse.

Every interval is taken from the memory's nanosecond minima for the selected speed grade. Each minimum is turned into clock cycles at elaboration by rounding up against an integer clock period. The intervals are the full cycle time, the pulse width, the chip-enable-to-end width, the data and address setup to the end of the write, and the time the memory needs to float its outputs. The data bus is driven only inside the pulse. It is released on the edge that ends the write, so the memory's outputs can come back on without a clash. A busy level and a one-cycle done pulse form the handshake toward the requester.

Top module: `sram_wr_seq`

## Requirements
- R1: From the first cycle in which either strobe is low until done is raised, at least the grade's cycle time passes (25, 35 or 45 ns for GRADE 0, 1, 2).
- R2: Both strobes stay low together for at least the grade's pulse width (20, 25 or 30 ns). Chip enable is low for at least the same time, counted up to the end of the write.
- R3: The data bus is driven with the requested word for at least the grade's data setup (10, 12 or 15 ns) before the write ends. It is never driven in a cycle where either strobe is high, which gives zero hold and releases the bus no later than the end of the write.
- R4: The address pins hold the request address for at least the grade's address setup (20, 25 or 30 ns) before the write ends. The address pins change only on an edge whose preceding cycle had both strobes high.
- R5: With reqCeMode = 0 (write-enable shaped), chip enable falls one cycle while write enable is still high. The data bus is then held off for at least the float time (10, 13 or 14 ns) after write enable falls.
- R6: With reqCeMode = 1 (chip-enable shaped), write enable falls at least one cycle before chip enable falls, and the data bus may be driven from the first pulse cycle.
- R7: memSaveN is high in every cycle.
- R8: A request is taken only while busy is low. busy stays high from the cycle after acceptance through the done cycle. done is high for exactly one cycle, and a request held valid is accepted in the cycle right after done.
- R9: A request presented while busy is ignored: the address pins keep the accepted address and only one write cycle appears on the pins.
- R10: After reset both strobes are high, the data bus is not driven, the save strobe is high, and busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS nanoseconds |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Write request present |
| reqAddr | input | ADDR_W | Write address |
| reqData | input | DATA_W | Write data |
| reqCeMode | input | 1 | 0: write enable shapes the pulse; 1: chip enable shapes it |
| busy | output | 1 | A write cycle is in progress |
| done | output | 1 | One-cycle pulse when the cycle time has elapsed |
| memAddr | output | ADDR_W | Memory address bus |
| memCeN | output | 1 | Memory chip enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memDataOut | output | DATA_W | Value for the memory data bus |
| memDataOe | output | 1 | Data bus drive enable |
| memSaveN | output | 1 | Hardware save strobe, held high |

## Verification
Two things can meet in one cycle. The release of the data bus falls on the same edge as the end of the write, and a new request can arrive on the edge that follows done. The bench drives each shape on three instances, one per speed grade. A pin monitor records how long the bus was driven inside the pulse and flags any drive outside it. The bench also holds reqValid high across done and requires busy to be low for exactly one cycle and then high again. A pin monitor measures every interval in nanoseconds and judges it against the grade's minima.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_PULSE,
    ST_RECOV,
    ST_DONE
  } wrState_t;

  typedef struct packed {
    logic load;
    logic ceOn;
    logic weOn;
    logic drive;
  } wrStrobe_t;

  function automatic int nsToCyc(input int ns, input int periodNs);
    return (ns <= 0) ? 0 : (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int pickNs(input int grade, input int g0, input int g1, input int g2);
    case (grade)
      0:       return g0;
      1:       return g1;
      default: return g2;
    endcase
  endfunction

  function automatic int maxI(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
  import sram_wr_pkg::*;
#(
  parameter int GRADE  = 0,
  parameter int CLK_NS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqCeMode,
  output logic      busy,
  output logic      done,
  output wrStrobe_t strobe
);

  localparam int N_WC  = nsToCyc(pickNs(GRADE, 25, 35, 45), CLK_NS);
  localparam int N_PWE = nsToCyc(pickNs(GRADE, 20, 25, 30), CLK_NS);
  localparam int N_SCE = nsToCyc(pickNs(GRADE, 20, 25, 30), CLK_NS);
  localparam int N_SD  = nsToCyc(pickNs(GRADE, 10, 12, 15), CLK_NS);
  localparam int N_AW  = nsToCyc(pickNs(GRADE, 20, 25, 30), CLK_NS);
  localparam int N_HZ  = nsToCyc(pickNs(GRADE, 10, 13, 14), CLK_NS);

  localparam int P_WE = maxI(1, maxI(maxI(N_PWE, N_AW - 1), N_HZ + N_SD));
  localparam int P_CE = maxI(1, maxI(maxI(N_PWE, N_SCE), maxI(N_AW - 1, N_SD)));
  localparam int R_WE = maxI(0, N_WC - 1 - P_WE);
  localparam int R_CE = maxI(0, N_WC - 1 - P_CE);
  localparam int CNT_MAX = maxI(maxI(P_WE, P_CE), maxI(R_WE, R_CE));
  localparam int CNT_W = $clog2(CNT_MAX + 1) + 1;

  localparam logic [CNT_W-1:0] PULSE_WE = CNT_W'(P_WE);
  localparam logic [CNT_W-1:0] PULSE_CE = CNT_W'(P_CE);
  localparam logic [CNT_W-1:0] RECOV_WE = CNT_W'(R_WE);
  localparam logic [CNT_W-1:0] RECOV_CE = CNT_W'(R_CE);
  localparam logic [CNT_W-1:0] HZ_WAIT  = CNT_W'(N_HZ);

  wrState_t         state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             modeQ, nextMode;
  logic             accept;
  logic [CNT_W-1:0] pulseLen, recovLen;

  assign pulseLen = modeQ ? PULSE_CE : PULSE_WE;
  assign recovLen = modeQ ? RECOV_CE : RECOV_WE;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    nextMode  = modeQ;
    accept    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          accept    = 1'b1;
          nextMode  = reqCeMode;
          nextState = ST_LEAD;
          nextCnt   = '0;
        end
      end
      ST_LEAD: begin
        nextState = ST_PULSE;
        nextCnt   = '0;
      end
      ST_PULSE: begin
        if (cnt == pulseLen - 1'b1) begin
          nextCnt   = '0;
          nextState = (recovLen == '0) ? ST_DONE : ST_RECOV;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt == recovLen - 1'b1) begin
          nextCnt   = '0;
          nextState = ST_DONE;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_DONE:  nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  // Strobes describe the pin state of the coming cycle; the datapath registers them.
  always_comb begin
    strobe.load  = accept;
    strobe.ceOn  = (nextState == ST_PULSE) || (nextState == ST_LEAD && !nextMode);
    strobe.weOn  = (nextState == ST_PULSE) || (nextState == ST_LEAD && nextMode);
    strobe.drive = (nextState == ST_PULSE) && (nextMode || nextCnt >= HZ_WAIT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      modeQ <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      modeQ <= nextMode;
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

endmodule

// File: rtl/sram_wr_dp.sv
module sram_wr_dp
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic              memSaveN
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memAddr    <= '0;
      memDataOut <= '0;
      memCeN     <= 1'b1;
      memWeN     <= 1'b1;
      memDataOe  <= 1'b0;
    end else begin
      if (strobe.load) begin
        memAddr    <= reqAddr;
        memDataOut <= reqData;
      end
      memCeN    <= !strobe.ceOn;
      memWeN    <= !strobe.weOn;
      memDataOe <= strobe.drive;
    end
  end

  assign memSaveN = 1'b1;

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
  import sram_wr_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int GRADE  = 0,
  parameter int CLK_NS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic              reqCeMode,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic              memSaveN
);

  wrStrobe_t strobe;

  sram_wr_ctrl #(.GRADE(GRADE), .CLK_NS(CLK_NS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqCeMode (reqCeMode),
    .busy      (busy),
    .done      (done),
    .strobe    (strobe)
  );

  sram_wr_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqAddr    (reqAddr),
    .reqData    (reqData),
    .memAddr    (memAddr),
    .memCeN     (memCeN),
    .memWeN     (memWeN),
    .memDataOut (memDataOut),
    .memDataOe  (memDataOe),
    .memSaveN   (memSaveN)
  );

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCeN,
  input logic              memWeN,
  input logic              memDataOe,
  input logic              memSaveN
);

  AST_SAVE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    memSaveN); // R7

  AST_BUS_IN_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> (!memCeN && !memWeN)); // R3

  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(memAddr) |-> $past(memCeN && memWeN)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8

  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy); // R8

  AST_CE_AFTER_WE: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memCeN) && !memWeN) |-> $past(!memWeN)); // R6

endmodule

bind sram_wr_seq sram_wr_seq_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .memAddr   (memAddr),
  .memCeN    (memCeN),
  .memWeN    (memWeN),
  .memDataOe (memDataOe),
  .memSaveN  (memSaveN)
);

// File: tb/sim_sram_wr_seq.sv
module sim_pinmon #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int GRADE  = 0,
  parameter int CLK_NS = 4
) (
  input logic              clk,
  input logic              ceN,
  input logic              weN,
  input logic              oe,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] data,
  input logic              saveN,
  input logic              done
);

  int writes = 0, pulseCyc = 0, ceCyc = 0, setupCyc = 0, addrCyc = 0;
  int hzCyc = 0, cycCyc = 0, doneCyc = 0, contention = 0, addrViol = 0, saveViol = 0;
  int pulseRun = 0, ceRun = 0, weRun = 0, drvRun = 0, addrRun = 0, cycRun = 0, doneRun = 0;
  int lastCe = 0, lastAddr = 0;
  bit weFirst = 0, oeSeen = 0, inCycle = 0, prevActive = 0, prevCeN = 1, prevWeN = 1;
  logic [ADDR_W-1:0] prevAddr = '0;
  logic [DATA_W-1:0] dataAtEnd = '0;

  function automatic int gNs(input int a, input int b, input int c);
    return (GRADE == 0) ? a : (GRADE == 1) ? b : c;
  endfunction

  always @(negedge clk) begin
    automatic bit active = !ceN && !weN;
    if (addr !== prevAddr) begin
      addrRun = 1;
      if (!(prevCeN && prevWeN)) addrViol++;
    end else addrRun++;
    if (!saveN) saveViol++;
    if (oe && !active) contention++;
    ceRun = ceN ? 0 : ceRun + 1;
    weRun = weN ? 0 : weRun + 1;
    if (!ceN && prevCeN) weFirst = !prevWeN;
    if (active) begin
      pulseRun++;
      if (oe) begin
        if (!oeSeen) hzCyc = weRun - 1;
        oeSeen = 1;
        drvRun++;
        dataAtEnd = data;
      end else drvRun = 0;
      lastCe = ceRun;
      lastAddr = addrRun;
    end
    if (!active && prevActive) begin
      pulseCyc = pulseRun; ceCyc = lastCe; setupCyc = drvRun; addrCyc = lastAddr;
      writes++;
      pulseRun = 0; drvRun = 0; oeSeen = 0;
    end
    if (!inCycle && (!ceN || !weN)) begin inCycle = 1; cycRun = 0; end
    if (inCycle) begin
      if (done) begin cycCyc = cycRun; inCycle = 0; end
      else cycRun++;
    end
    if (done) doneRun++;
    else if (doneRun != 0) begin doneCyc = doneRun; doneRun = 0; end
    prevActive = active; prevCeN = ceN; prevWeN = weN; prevAddr = addr;
  end

  task automatic one(input bit ok, input string req, input int act, input int exp,
                     inout int nChk, inout int nFail);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s grade %0d: actual %0d expected %0d", req, GRADE, act, exp);
    end
  endtask

  // Judges the last completed write against the grade minima, in nanoseconds.
  task automatic judge(input bit ceMode, input logic [DATA_W-1:0] d, inout int nChk, inout int nFail);
    one(cycCyc * CLK_NS >= gNs(25, 35, 45), "R1 cycle ns", cycCyc * CLK_NS, gNs(25, 35, 45), nChk, nFail);
    one(pulseCyc * CLK_NS >= gNs(20, 25, 30), "R2 pulse ns", pulseCyc * CLK_NS, gNs(20, 25, 30), nChk, nFail);
    one(ceCyc * CLK_NS >= gNs(20, 25, 30), "R2 ce-to-end ns", ceCyc * CLK_NS, gNs(20, 25, 30), nChk, nFail);
    one(setupCyc * CLK_NS >= gNs(10, 12, 15), "R3 data setup ns", setupCyc * CLK_NS, gNs(10, 12, 15), nChk, nFail);
    one(dataAtEnd == d, "R3 data value", int'(dataAtEnd), int'(d), nChk, nFail);
    one(contention == 0, "R3 drive outside pulse", contention, 0, nChk, nFail);
    one(addrCyc * CLK_NS >= gNs(20, 25, 30), "R4 addr setup ns", addrCyc * CLK_NS, gNs(20, 25, 30), nChk, nFail);
    one(addrViol == 0, "R4 addr change under strobe", addrViol, 0, nChk, nFail);
    if (!ceMode) begin
      one(hzCyc * CLK_NS >= gNs(10, 13, 14), "R5 float wait ns", hzCyc * CLK_NS, gNs(10, 13, 14), nChk, nFail);
      one(weFirst == 0, "R5 ce before we", int'(weFirst), 0, nChk, nFail);
    end else begin
      one(weFirst == 1, "R6 we before ce", int'(weFirst), 1, nChk, nFail);
    end
    one(saveViol == 0, "R7 save strobe", saveViol, 0, nChk, nFail);
    one(doneCyc == 1, "R8 done width", doneCyc, 1, nChk, nFail);
  endtask

endmodule

module sim_sram_wr_seq;
  localparam int AW = 13, DW = 8, CLK = 4;

  logic clk = 1'b0, rstN = 1'b0, reqValid = 1'b0, reqCeMode = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic busy0, busy1, busy2, done0, done1, done2;
  logic ce0, ce1, ce2, we0, we1, we2, oe0, oe1, oe2, sv0, sv1, sv2;
  logic [AW-1:0] a0, a1, a2;
  logic [DW-1:0] d0, d1, d2;
  int nChk = 0, nFail = 0;

  always #(CLK / 2) clk = ~clk;

  sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .GRADE(0), .CLK_NS(CLK)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqData(reqData),
    .reqCeMode(reqCeMode), .busy(busy0), .done(done0), .memAddr(a0), .memCeN(ce0),
    .memWeN(we0), .memDataOut(d0), .memDataOe(oe0), .memSaveN(sv0));
  sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .GRADE(1), .CLK_NS(CLK)) u1 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqData(reqData),
    .reqCeMode(reqCeMode), .busy(busy1), .done(done1), .memAddr(a1), .memCeN(ce1),
    .memWeN(we1), .memDataOut(d1), .memDataOe(oe1), .memSaveN(sv1));
  sram_wr_seq #(.ADDR_W(AW), .DATA_W(DW), .GRADE(2), .CLK_NS(CLK)) u2 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .reqData(reqData),
    .reqCeMode(reqCeMode), .busy(busy2), .done(done2), .memAddr(a2), .memCeN(ce2),
    .memWeN(we2), .memDataOut(d2), .memDataOe(oe2), .memSaveN(sv2));

  sim_pinmon #(.ADDR_W(AW), .DATA_W(DW), .GRADE(0), .CLK_NS(CLK)) m0 (
    .clk(clk), .ceN(ce0), .weN(we0), .oe(oe0), .addr(a0), .data(d0), .saveN(sv0), .done(done0));
  sim_pinmon #(.ADDR_W(AW), .DATA_W(DW), .GRADE(1), .CLK_NS(CLK)) m1 (
    .clk(clk), .ceN(ce1), .weN(we1), .oe(oe1), .addr(a1), .data(d1), .saveN(sv1), .done(done1));
  sim_pinmon #(.ADDR_W(AW), .DATA_W(DW), .GRADE(2), .CLK_NS(CLK)) m2 (
    .clk(clk), .ceN(ce2), .weN(we2), .oe(oe2), .addr(a2), .data(d2), .saveN(sv2), .done(done2));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitIdle();
    int guard = 0;
    while ((busy0 || busy1 || busy2) && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(ce0 && ce1 && ce2 && we0 && we1 && we2, "R10 strobes high", {ce0, we0}, 3);
    chk(!oe0 && !oe1 && !oe2, "R10 bus off", oe0, 0);
    chk(!busy0 && !busy1 && !busy2 && !done0 && !done1 && !done2, "R10 busy/done low", busy0, 0);
    chk(sv0 && sv1 && sv2, "R10 R7 save high", sv0, 1);
  endtask

  task automatic testWrite(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ceMode);
    int w0 = m0.writes;
    @(negedge clk);
    reqAddr = a; reqData = d; reqCeMode = ceMode; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy0 && busy1 && busy2, "R8 busy after accept", busy0, 1);
    waitIdle();
    chk(m0.writes == w0 + 1, "R8 one write", m0.writes - w0, 1);
    chk(a0 == a && a2 == a, "R4 address on pins", int'(a0), int'(a));
    m0.judge(ceMode, d, nChk, nFail);
    m1.judge(ceMode, d, nChk, nFail);
    m2.judge(ceMode, d, nChk, nFail);
  endtask

  task automatic testBusyIgnore();
    int w0 = m0.writes, w2 = m2.writes;
    @(negedge clk);
    reqAddr = 13'h0abc; reqData = 8'h3c; reqCeMode = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    reqAddr = 13'h1555; reqData = 8'hc3; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    waitIdle();
    chk(a0 == 13'h0abc, "R9 address kept (grade 0)", int'(a0), 'h0abc);
    chk(a2 == 13'h0abc, "R9 address kept (grade 2)", int'(a2), 'h0abc);
    chk(m0.writes == w0 + 1 && m2.writes == w2 + 1, "R9 single write", m0.writes - w0, 1);
    m0.judge(1'b0, 8'h3c, nChk, nFail);
  endtask

  task automatic testBackToBack();
    int guard = 0;
    @(negedge clk);
    reqAddr = 13'h0101; reqData = 8'h5a; reqCeMode = 1'b1; reqValid = 1'b1;
    while (!done0 && guard < 100) begin @(negedge clk); guard++; end
    chk(done0, "R8 done reached", done0, 1);
    @(negedge clk);
    chk(!busy0 && !done0, "R8 idle one cycle after done", busy0, 0);
    @(negedge clk);
    chk(busy0, "R8 held request taken next cycle", busy0, 0 + 1);
    reqValid = 1'b0;
    waitIdle();
    m0.judge(1'b1, 8'h5a, nChk, nFail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWrite(13'h1234, 8'ha5, 1'b0);
    testWrite(13'h0f0f, 8'h5a, 1'b1);
    testWrite(13'h1fff, 8'hff, 1'b0);
    testWrite(13'h0000, 8'h00, 1'b1);
    testBusyIgnore();
    testBackToBack();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    #(CLK * 200000);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule